// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block is a small, fully associative cache of address translations. Each slot holds a virtual page number, the address space identifier of the context that loaded it, a physical frame number, and the page's protection flags. A lookup checks every slot in the same cycle. One cycle later the block answers in one of three ways: a translation (hit), a request for the external page-table walker to fetch the mapping (miss), or a protection fault.

A refill port writes a mapping that the walker has fetched. The refill is tagged with the identifier that is current at that moment. It goes to a free slot if one exists; otherwise it replaces the least recently used slot.

Changing the current identifier during a context switch leaves every slot in place. Slots of other contexts simply stop matching. A separate flush command drops every slot at once.

Top module: `tlb_asid_cache`

## Requirements
- R1: A lookup hits when a valid slot holds the requested page number and an identifier equal to the current identifier register. The response appears on the cycle after the request, with the stored frame number on `rsp_pfn`.
- R2: A lookup that matches no slot gives `rsp_miss` high, with a frame number and dirty flag of zero.
- R3: A refill stores the mapping tagged with the current identifier. A lookup issued on the following cycle hits it.
- R4: Writing the identifier register invalidates no slot. Mappings of the previous identifier miss under the new one and hit again once the previous identifier is restored.
- R5: A flush invalidates every slot, so lookups issued after it miss. A refill presented in the same cycle as a flush is discarded.
- R6: After a flush, the block accepts ENTRIES refills of distinct pages without any of them displacing another, because free slots are always used before any eviction.
- R7: When every slot is valid, a refill replaces the slot whose last successful hit or refill is the oldest. Faulting lookups and misses do not count as use.
- R8: The access kind is encoded as 00 read, 01 write, 10 instruction fetch. A write that hits a read-only slot, or a fetch that hits a no-execute slot, gives `rsp_fault` high instead of a translation, with a frame number of zero. Such an access changes neither the dirty flag nor the use order.
- R9: A write hit to a slot with a clear dirty flag sets that flag. The write response, and every later hit on that slot, reports `rsp_dirty` high.
- R10: Every lookup produces exactly one response cycle, one cycle later. In that cycle exactly one of hit, miss and fault is high. Outside response cycles all three are low.
- R11: A read hit on a read-only slot is an ordinary hit. Access kind 11 is treated as a read.
- R12: After reset, every slot is invalid, the identifier register is zero, and no response is pending.
- R13: If several valid slots match, the lowest-numbered slot supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| asid_wr_en | input | 1 | Load the current identifier register |
| asid_wr_data | input | ASID_W | New identifier value |
| flush_all | input | 1 | Invalidate every slot |
| lkp_valid | input | 1 | Lookup request |
| lkp_vpn | input | VPN_W | Virtual page number to translate |
| lkp_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| refill_en | input | 1 | Write a fetched mapping |
| refill_vpn | input | VPN_W | Page number of the mapping |
| refill_pfn | input | PFN_W | Frame number of the mapping |
| refill_ro | input | 1 | Page is read-only |
| refill_nx | input | 1 | Page is not executable |
| refill_dirty | input | 1 | Initial dirty flag |
| rsp_valid | output | 1 | Response cycle |
| rsp_hit | output | 1 | Translation returned |
| rsp_miss | output | 1 | Walker must fetch the mapping |
| rsp_fault | output | 1 | Protection violation |
| rsp_pfn | output | PFN_W | Translated frame number (zero unless hit) |
| rsp_ro | output | 1 | Read-only flag of the hit slot |
| rsp_nx | output | 1 | No-execute flag of the hit slot |
| rsp_dirty | output | 1 | Dirty flag of the hit slot after the access |

## Verification
The bench builds the block with four slots, 12-bit page numbers, 10-bit frame numbers and 4-bit identifiers. With four slots, a handful of refills fills the table, so the following are all reached within a few dozen cycles: eviction of the least recently used slot, reuse of free slots after a flush, and the lowest-slot rule for a duplicated page. The narrow identifier still leaves room to switch between two contexts whose mappings share one page number.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Access kind carried with each lookup.
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/tlb_cam_match.sv
// Parallel compare of one key against every slot; the lowest matching slot wins.
module tlb_cam_match #(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [N-1:0]             ent_vld,
    input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [N-1:0][ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic                     any_hit,
    output logic [IDX_W-1:0]         hit_idx
);

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ent_vld[g] && (ent_vpn[g] == key_vpn) && (ent_asid[g] == key_asid);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign any_hit = |match;

endmodule

// File: rtl/tlb_age_update.sv
// Age-based recency: touched slot becomes 0, younger slots age by one.
module tlb_age_update #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0][IDX_W-1:0] ages_i,
    input  logic                    touch,
    input  logic [IDX_W-1:0]        touch_idx,
    output logic [N-1:0][IDX_W-1:0] ages_o
);

    always_comb begin
        ages_o = ages_i;
        if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (ages_i[i] < ages_i[touch_idx]) ages_o[i] = ages_i[i] + IDX_W'(1);
            end
            ages_o[touch_idx] = '0;
        end
    end

endmodule

// File: rtl/tlb_victim_pick.sv
// Chooses the refill target: lowest free slot, else the oldest slot.
module tlb_victim_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]            ent_vld,
    input  logic [N-1:0][IDX_W-1:0] ages,
    output logic [IDX_W-1:0]        victim
);

    localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(N - 1);

    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (ages[i] == AGE_MAX) old_idx = IDX_W'(i);
        end
        victim = free_any ? free_idx : old_idx;
    end

endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              asid_wr_en,
    input  logic [ASID_W-1:0] asid_wr_data,
    input  logic              flush_all,
    input  logic              lkp_valid,
    input  logic [VPN_W-1:0]  lkp_vpn,
    input  logic [1:0]        lkp_kind,
    input  logic              refill_en,
    input  logic [VPN_W-1:0]  refill_vpn,
    input  logic [PFN_W-1:0]  refill_pfn,
    input  logic              refill_ro,
    input  logic              refill_nx,
    input  logic              refill_dirty,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic              rsp_ro,
    output logic              rsp_nx,
    output logic              rsp_dirty
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
        logic [ENTRIES-1:0]             ro;
        logic [ENTRIES-1:0]             nx;
        logic [ENTRIES-1:0]             dty;
        logic [ENTRIES-1:0][IDX_W-1:0]  age;
        logic [ASID_W-1:0]              cur_asid;
        logic                           r_vld;
        logic                           r_hit;
        logic                           r_miss;
        logic                           r_flt;
        logic [PFN_W-1:0]               r_pfn;
        logic                           r_ro;
        logic                           r_nx;
        logic                           r_dty;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < ENTRIES; i++) s.age[i] = IDX_W'(i);
        return s;
    endfunction

    state_t st_q, st_d;

    // ---- lookup decode ----
    logic                          cam_hit;
    logic [IDX_W-1:0]              cam_idx;
    logic [IDX_W-1:0]              fill_idx;
    logic [ENTRIES-1:0][IDX_W-1:0] age_mid;
    logic [ENTRIES-1:0][IDX_W-1:0] age_fin;
    logic                          acc_wr;
    logic                          acc_fx;
    logic                          deny;
    logic                          hit_use;
    logic                          fill_do;

    tlb_cam_match #(
        .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
    ) u_cam (
        .ent_vld  (st_q.vld),
        .ent_vpn  (st_q.vpn),
        .ent_asid (st_q.asid),
        .key_vpn  (lkp_vpn),
        .key_asid (st_q.cur_asid),
        .any_hit  (cam_hit),
        .hit_idx  (cam_idx)
    );

    tlb_victim_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_vict (
        .ent_vld (st_q.vld),
        .ages    (st_q.age),
        .victim  (fill_idx)
    );

    assign acc_wr  = (lkp_kind == ACC_WRITE);
    assign acc_fx  = (lkp_kind == ACC_FETCH);
    assign deny    = (acc_wr && st_q.ro[cam_idx]) || (acc_fx && st_q.nx[cam_idx]);
    assign hit_use = lkp_valid && cam_hit && !deny;
    assign fill_do = refill_en && !flush_all;

    // Hit is applied first, refill second: a refill always ends most recent.
    tlb_age_update #(.N(ENTRIES), .IDX_W(IDX_W)) u_age_hit (
        .ages_i    (st_q.age),
        .touch     (hit_use),
        .touch_idx (cam_idx),
        .ages_o    (age_mid)
    );

    tlb_age_update #(.N(ENTRIES), .IDX_W(IDX_W)) u_age_fill (
        .ages_i    (age_mid),
        .touch     (fill_do),
        .touch_idx (fill_idx),
        .ages_o    (age_fin)
    );

    // ---- next state ----
    always_comb begin
        st_d        = st_q;
        st_d.r_vld  = lkp_valid;
        st_d.r_hit  = 1'b0;
        st_d.r_miss = 1'b0;
        st_d.r_flt  = 1'b0;
        st_d.r_pfn  = '0;
        st_d.r_ro   = 1'b0;
        st_d.r_nx   = 1'b0;
        st_d.r_dty  = 1'b0;

        if (lkp_valid) begin
            if (!cam_hit) begin
                st_d.r_miss = 1'b1;
            end else if (deny) begin
                st_d.r_flt = 1'b1;
            end else begin
                st_d.r_hit = 1'b1;
                st_d.r_pfn = st_q.pfn[cam_idx];
                st_d.r_ro  = st_q.ro[cam_idx];
                st_d.r_nx  = st_q.nx[cam_idx];
                st_d.r_dty = st_q.dty[cam_idx] || acc_wr;
                if (acc_wr) st_d.dty[cam_idx] = 1'b1;
            end
        end

        if (fill_do) begin
            st_d.vld[fill_idx]  = 1'b1;
            st_d.vpn[fill_idx]  = refill_vpn;
            st_d.asid[fill_idx] = st_q.cur_asid;
            st_d.pfn[fill_idx]  = refill_pfn;
            st_d.ro[fill_idx]   = refill_ro;
            st_d.nx[fill_idx]   = refill_nx;
            st_d.dty[fill_idx]  = refill_dirty;
        end

        st_d.age = age_fin;

        if (flush_all) st_d.vld = '0;
        if (asid_wr_en) st_d.cur_asid = asid_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.r_vld;
    assign rsp_hit   = st_q.r_hit;
    assign rsp_miss  = st_q.r_miss;
    assign rsp_fault = st_q.r_flt;
    assign rsp_pfn   = st_q.r_pfn;
    assign rsp_ro    = st_q.r_ro;
    assign rsp_nx    = st_q.r_nx;
    assign rsp_dirty = st_q.r_dty;

endmodule

// File: rtl/tlb_asid_cache_chk.sv
module tlb_asid_cache_chk
    import tlb_pkg::*;
#(
    parameter int PFN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lkp_valid,
    input logic [1:0]       lkp_kind,
    input logic             flush_all,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_fault,
    input logic [PFN_W-1:0] rsp_pfn,
    input logic             rsp_ro,
    input logic             rsp_nx,
    input logic             rsp_dirty
);

    // R10
    rsp_one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    // R10
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid);

    // R5
    flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all ##1 lkp_valid) |=> rsp_miss);

    // R8
    fault_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_pfn == '0);

    // R8
    write_hit_writable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(lkp_kind) == ACC_WRITE) |-> !rsp_ro);

    // R8
    fetch_hit_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(lkp_kind) == ACC_FETCH) |-> !rsp_nx);

    // R9
    write_hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(lkp_kind) == ACC_WRITE) |-> rsp_dirty);

endmodule

bind tlb_asid_cache tlb_asid_cache_chk #(.PFN_W(PFN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .lkp_kind  (lkp_kind),
    .flush_all (flush_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_pfn   (rsp_pfn),
    .rsp_ro    (rsp_ro),
    .rsp_nx    (rsp_nx),
    .rsp_dirty (rsp_dirty)
);

// File: tb/tb_tlb_asid_cache.sv
`timescale 1ns/1ps
module tb_tlb_asid_cache;

    localparam int ENTRIES = 4;
    localparam int VPN_W   = 12;
    localparam int PFN_W   = 10;
    localparam int ASID_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              asid_wr_en = 1'b0;
    logic [ASID_W-1:0] asid_wr_data = '0;
    logic              flush_all = 1'b0;
    logic              lkp_valid = 1'b0;
    logic [VPN_W-1:0]  lkp_vpn = '0;
    logic [1:0]        lkp_kind = '0;
    logic              refill_en = 1'b0;
    logic [VPN_W-1:0]  refill_vpn = '0;
    logic [PFN_W-1:0]  refill_pfn = '0;
    logic              refill_ro = 1'b0;
    logic              refill_nx = 1'b0;
    logic              refill_dirty = 1'b0;
    logic              rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [PFN_W-1:0]  rsp_pfn;
    logic              rsp_ro, rsp_nx, rsp_dirty;

    always #4 clk = ~clk;

    tlb_asid_cache #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .asid_wr_en(asid_wr_en), .asid_wr_data(asid_wr_data),
        .flush_all(flush_all),
        .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn), .lkp_kind(lkp_kind),
        .refill_en(refill_en), .refill_vpn(refill_vpn), .refill_pfn(refill_pfn),
        .refill_ro(refill_ro), .refill_nx(refill_nx), .refill_dirty(refill_dirty),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn), .rsp_ro(rsp_ro),
        .rsp_nx(rsp_nx), .rsp_dirty(rsp_dirty)
    );

    typedef struct {
        logic             hit;
        logic             miss;
        logic             flt;
        logic [PFN_W-1:0] pfn;
        logic             dty;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    localparam logic [1:0] RD = 2'b00, WR = 2'b01, FX = 2'b10, K3 = 2'b11;

    task automatic clear_inputs();
        asid_wr_en = 1'b0;  flush_all = 1'b0;
        lkp_valid  = 1'b0;  lkp_vpn   = '0;  lkp_kind = RD;
        refill_en  = 1'b0;  refill_vpn = '0; refill_pfn = '0;
        refill_ro  = 1'b0;  refill_nx = 1'b0; refill_dirty = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        clear_inputs();
    endtask

    // Driver: present one lookup and queue what the requirements predict.
    task automatic look(input logic [VPN_W-1:0] v, input logic [1:0] k,
                        input logic eh, input logic em, input logic ef,
                        input logic [PFN_W-1:0] ep, input logic ed, input string tag);
        exp_t e;
        @(negedge clk);
        clear_inputs();
        lkp_valid = 1'b1; lkp_vpn = v; lkp_kind = k;
        e.hit = eh; e.miss = em; e.flt = ef; e.pfn = ep; e.dty = ed; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                        input logic ro, input logic nx, input logic dty, input logic fl);
        @(negedge clk);
        clear_inputs();
        refill_en = 1'b1; refill_vpn = v; refill_pfn = p;
        refill_ro = ro; refill_nx = nx; refill_dirty = dty;
        flush_all = fl;
    endtask

    task automatic flush();
        @(negedge clk);
        clear_inputs();
        flush_all = 1'b1;
    endtask

    task automatic set_asid(input logic [ASID_W-1:0] a);
        @(negedge clk);
        clear_inputs();
        asid_wr_en = 1'b1; asid_wr_data = a;
    endtask

    // Monitor: pop and compare each response as it appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected response: hit=%0b miss=%0b fault=%0b, expected none",
                         rsp_hit, rsp_miss, rsp_fault);
            end else begin
                mon_e = exp_q.pop_front();
                if (rsp_hit !== mon_e.hit || rsp_miss !== mon_e.miss || rsp_fault !== mon_e.flt ||
                    rsp_pfn !== mon_e.pfn || rsp_dirty !== mon_e.dty) begin
                    errors++;
                    $display("FAIL %s: actual hit=%0b miss=%0b fault=%0b pfn=%h dirty=%0b expected hit=%0b miss=%0b fault=%0b pfn=%h dirty=%0b",
                             mon_e.tag, rsp_hit, rsp_miss, rsp_fault, rsp_pfn, rsp_dirty,
                             mon_e.hit, mon_e.miss, mon_e.flt, mon_e.pfn, mon_e.dty);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        // R12: nothing pending while in reset
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset response: actual %0b expected 0", rsp_valid);
        end
        rst_n = 1'b1;
        idle();
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R12 after reset: actual %0b expected 0", rsp_valid);
        end

        look(12'h010, RD, 0, 1, 0, '0, 0, "R12 R2 empty table misses");
        fill(12'h010, 10'h101, 0, 0, 0, 0);
        look(12'h010, RD, 1, 0, 0, 10'h101, 0, "R1 R3 refill then hit");
        fill(12'h020, 10'h202, 1, 0, 0, 0);
        fill(12'h030, 10'h303, 0, 1, 0, 0);
        fill(12'h040, 10'h004, 0, 0, 0, 0);
        look(12'h020, RD, 1, 0, 0, 10'h202, 0, "R11 read of read-only page hits");
        look(12'h020, WR, 0, 0, 1, '0, 0, "R8 write to read-only faults");
        look(12'h030, FX, 0, 0, 1, '0, 0, "R8 fetch of no-execute faults");
        look(12'h030, RD, 1, 0, 0, 10'h303, 0, "R1 read of no-execute page");
        look(12'h040, WR, 1, 0, 0, 10'h004, 1, "R9 write hit sets dirty");
        look(12'h040, RD, 1, 0, 0, 10'h004, 1, "R9 dirty persists");

        // use order now 010,020,030,040; refresh 010 so 020 is oldest
        look(12'h010, RD, 1, 0, 0, 10'h101, 0, "R1 refresh use");
        fill(12'h050, 10'h055, 0, 0, 0, 0);
        look(12'h020, RD, 0, 1, 0, '0, 0, "R7 oldest slot evicted");
        look(12'h010, RD, 1, 0, 0, 10'h101, 0, "R7 refreshed slot kept");
        look(12'h050, RD, 1, 0, 0, 10'h055, 0, "R7 new mapping present");

        // context switch: order now 030,040,010,050
        set_asid(4'h5);
        look(12'h010, RD, 0, 1, 0, '0, 0, "R4 other context misses");
        fill(12'h010, 10'h1AA, 0, 0, 0, 0);
        look(12'h010, RD, 1, 0, 0, 10'h1AA, 0, "R4 new context mapping");
        set_asid(4'h0);
        look(12'h010, RD, 1, 0, 0, 10'h101, 0, "R4 old mapping survives switch");
        look(12'h030, RD, 0, 1, 0, '0, 0, "R7 oldest evicted by context refill");
        look(12'h040, RD, 1, 0, 0, 10'h004, 1, "R4 R9 mapping and dirty kept");
        look(12'h050, K3, 1, 0, 0, 10'h055, 0, "R11 kind 11 acts as read");
        look(12'h050, WR, 1, 0, 0, 10'h055, 1, "R9 write hit on clean page");

        flush();
        look(12'h010, RD, 0, 1, 0, '0, 0, "R5 flush invalidates");
        look(12'h040, RD, 0, 1, 0, '0, 0, "R5 flush invalidates all");
        fill(12'h060, 10'h066, 0, 0, 0, 1);
        look(12'h060, RD, 0, 1, 0, '0, 0, "R5 refill with flush discarded");

        for (int i = 0; i < ENTRIES; i++)
            fill(12'h100 + 12'(i), 10'h3C0 + 10'(i), 0, 0, 0, 0);
        for (int i = 0; i < ENTRIES; i++)
            look(12'h100 + 12'(i), RD, 1, 0, 0, 10'h3C0 + 10'(i), 0, "R6 free slots filled first");

        flush();
        fill(12'h200, 10'h011, 0, 0, 0, 0);
        fill(12'h200, 10'h022, 0, 0, 0, 0);
        look(12'h200, RD, 1, 0, 0, 10'h011, 0, "R13 lowest slot wins");

        // back-to-back lookups
        look(12'h200, RD, 1, 0, 0, 10'h011, 0, "R10 back-to-back first");
        look(12'h300, RD, 0, 1, 0, '0, 0, "R10 back-to-back second");

        idle();
        idle();
        idle();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule